// File: doc/BRIEF.md
# Selectable SHA Message Padder

This block sits between a byte-wide message source and a hash compression core. It turns a byte stream of any length into whole hash blocks. For the 32-bit-word hash family the blocks are 64 bytes. For the 64-bit-word family they are 128 bytes. In padding mode it forwards the message bytes, then emits a single 0x80 marker byte, then zero fill. The last bytes of the final block carry the message length in bits, most significant byte first. When that length field no longer fits behind the marker in the current block, the padder emits one extra block.

In accumulate mode, firmware has already padded the data and has taken charge of the hash state. The padder then forwards every byte unchanged and only frames the stream into blocks. It also keeps its first-block flag low, so the core does not reload its initial hash state.

Output is one byte per beat with valid/ready flow control. Each beat carries a block-end flag, a final-block flag and a first-block flag, so the core can collect a block and knows when to start and when to finish.

Top module: `sha_msg_padder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In padding mode (cfg_accum=0), the message bytes appear on out_data unchanged and in order. The byte right after the last message byte is 0x80.
- R3: After the 0x80 byte only zero bytes follow, up to the length field. The total number of output bytes per message is a multiple of the block size: 64 when cfg_wide=0, 128 when cfg_wide=1.
- R4: The last 8 bytes (cfg_wide=0) or 16 bytes (cfg_wide=1) of the final block hold the message length in bits, most significant byte first. In the 16-byte field the upper 8 bytes are zero. For example, a 3-byte message ends in the byte 0x18.
- R5: Let p be the block position of the 0x80 byte. When p is at or beyond the block size minus the length-field size, one extra block follows that holds zeros and then the length field. For example, a 56-byte message with 64-byte blocks yields 128 output bytes.
- R6: out_blk_end is 1 on the last byte of every block. out_final is 1 only on the last byte of a message's last block, and always together with out_blk_end.
- R7: In accumulate mode (cfg_accum=1), no byte is added and every byte passes through unchanged. out_blk_end is 1 on every block-size-th byte of the message and on the byte marked in_last. out_final is 1 exactly on the in_last byte.
- R8: out_init is 1 on every byte of a message's first block in padding mode. It is 0 on later blocks and on every byte in accumulate mode.
- R9: cfg_wide and cfg_accum are sampled with the first byte of a message. Changes later in the same message have no effect on its output.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 128-byte blocks with a 16-byte length field; 0 selects 64-byte blocks with an 8-byte field |
| cfg_accum | input | 1 | 1 selects accumulate (pass-through) mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Padder accepts an input byte this cycle |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Marks the last byte of a message |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Core accepts the output byte |
| out_data | output | 8 | Padded stream byte |
| out_blk_end | output | 1 | Last byte of a block |
| out_final | output | 1 | Last byte of the message's last block |
| out_init | output | 1 | Byte belongs to the first block of a padded message |

## Verification
A wrong block position shows up within one block. Either the 0x80 marker lands at the wrong offset, or out_blk_end falls on the wrong byte. A wrong extra-block decision adds or drops a whole block, which changes the output byte count of that message. A stale length counter or a wrong mode latch corrupts only the trailing length bytes or the framing. The bench checks each message byte by byte against a model, so each of these faults is reported on the first beat it affects. Message lengths are placed around the fit limit of the length field, and the configuration is toggled in the middle of messages.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  typedef enum logic [1:0] {
    ST_DATA,
    ST_MARK,
    ST_TAIL
  } pad_state_e;

  typedef struct packed {
    logic [7:0] dat;
    logic       blk_end;
    logic       fin;
    logic       init;
  } pad_beat_t;

  localparam logic [7:0] MARK_BYTE = 8'h80;

endpackage

// File: rtl/sha_pad_len_ctr.sv
module sha_pad_len_ctr #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] bits
);

  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (start) begin
      bits <= BYTE_BITS;
    end else if (step) begin
      bits <= bits + BYTE_BITS;
    end
  end

endmodule

// File: rtl/sha_pad_tail_gen.sv
module sha_pad_tail_gen #(
  parameter int CNT_W = 64,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W:0]   len_start,
  input  logic [POS_W:0]   lfld,
  input  logic             extra,
  input  logic [CNT_W-1:0] bits,
  output logic [7:0]       tail_byte
);

  localparam int EXT_W   = POS_W + 1;
  localparam int CNT_BYT = CNT_W / 8;

  logic [POS_W:0] pos_x;
  logic [POS_W:0] k;
  logic [POS_W:0] sel;
  logic           in_len;

  assign pos_x  = {1'b0, pos};
  assign in_len = !extra && (pos_x >= len_start);
  assign k      = pos_x - len_start;
  assign sel    = lfld - EXT_W'(1) - k;

  // Counter bytes beyond CNT_BYT are the zero-extended upper field.
  always_comb begin
    tail_byte = 8'h00;
    for (int b = 0; b < CNT_BYT; b++) begin
      if (in_len && (sel == EXT_W'(b))) begin
        tail_byte = bits[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/sha_pad_out_stage.sv
module sha_pad_out_stage
  import sha_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  pad_beat_t din,
  input  logic      out_ready,
  output logic      can_take,
  output logic      valid,
  output pad_beat_t dout
);

  assign can_take = !valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (out_ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sha_msg_padder.sv
module sha_msg_padder
  import sha_pad_pkg::*;
#(
  parameter int BLK_NARROW  = 64,
  parameter int BLK_WIDE    = 128,
  parameter int LFLD_NARROW = 8,
  parameter int LFLD_WIDE   = 16,
  parameter int CNT_W       = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wide,
  input  logic       cfg_accum,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_blk_end,
  output logic       out_final,
  output logic       out_init
);

  localparam int POS_W = $clog2(BLK_WIDE);
  localparam int EXT_W = POS_W + 1;

  pad_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic             in_msg_q;
  logic             wide_q;
  logic             accum_q;
  logic             extra_q;
  logic             first_q;

  logic             wide_c;
  logic             accum_c;
  logic [POS_W:0]   blk_c;
  logic [POS_W:0]   lfld_c;
  logic [POS_W:0]   len_start;
  logic             pos_last;
  logic             can_take;
  logic             take_in;
  logic             emit;
  logic [7:0]       tail_byte;
  logic [CNT_W-1:0] bit_len;
  pad_beat_t        beat;
  pad_beat_t        out_beat;

  // Mode is taken live only for the first byte, then held (R9).
  assign wide_c    = in_msg_q ? wide_q  : cfg_wide;
  assign accum_c   = in_msg_q ? accum_q : cfg_accum;
  assign blk_c     = wide_c ? EXT_W'(BLK_WIDE)  : EXT_W'(BLK_NARROW);
  assign lfld_c    = wide_c ? EXT_W'(LFLD_WIDE) : EXT_W'(LFLD_NARROW);
  assign len_start = blk_c - lfld_c;
  assign pos_last  = ({1'b0, pos_q} == (blk_c - EXT_W'(1)));

  assign in_ready = (state_q == ST_DATA) && can_take;
  assign take_in  = in_valid && in_ready;
  assign emit     = take_in || ((state_q != ST_DATA) && can_take);

  sha_pad_len_ctr #(.CNT_W(CNT_W)) u_len (
    .clk   (clk),
    .rst   (rst),
    .start (take_in && !in_msg_q),
    .step  (take_in && in_msg_q),
    .bits  (bit_len)
  );

  sha_pad_tail_gen #(.CNT_W(CNT_W), .POS_W(POS_W)) u_tail (
    .pos       (pos_q),
    .len_start (len_start),
    .lfld      (lfld_c),
    .extra     (extra_q),
    .bits      (bit_len),
    .tail_byte (tail_byte)
  );

  always_comb begin
    beat = '0;
    unique case (state_q)
      ST_DATA: begin
        beat.dat     = in_data;
        beat.blk_end = pos_last || (accum_c && in_last);
        beat.fin     = accum_c && in_last;
        beat.init    = first_q && !accum_c;
      end
      ST_MARK: begin
        beat.dat     = MARK_BYTE;
        beat.blk_end = pos_last;
        beat.fin     = 1'b0;
        beat.init    = first_q;
      end
      ST_TAIL: begin
        beat.dat     = tail_byte;
        beat.blk_end = pos_last;
        beat.fin     = pos_last && !extra_q;
        beat.init    = first_q;
      end
      default: beat = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_DATA;
      pos_q    <= '0;
      in_msg_q <= 1'b0;
      wide_q   <= 1'b0;
      accum_q  <= 1'b0;
      extra_q  <= 1'b0;
      first_q  <= 1'b1;
    end else begin
      if (emit) begin
        pos_q <= beat.blk_end ? '0 : pos_q + POS_W'(1);
        if (beat.fin) begin
          first_q <= 1'b1;
        end else if (beat.blk_end) begin
          first_q <= 1'b0;
        end
      end
      unique case (state_q)
        ST_DATA: begin
          if (take_in) begin
            if (!in_msg_q) begin
              wide_q   <= cfg_wide;
              accum_q  <= cfg_accum;
              in_msg_q <= 1'b1;
            end
            if (in_last) begin
              if (accum_c) begin
                in_msg_q <= 1'b0;
              end else begin
                state_q <= ST_MARK;
              end
            end
          end
        end
        ST_MARK: begin
          if (can_take) begin
            // Marker too late for the length field: one more block (R5).
            extra_q <= !pos_last && ({1'b0, pos_q} >= len_start);
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (can_take && pos_last) begin
            if (extra_q) begin
              extra_q <= 1'b0;
            end else begin
              state_q  <= ST_DATA;
              in_msg_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_DATA;
      endcase
    end
  end

  sha_pad_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .din       (beat),
    .out_ready (out_ready),
    .can_take  (can_take),
    .valid     (out_valid),
    .dout      (out_beat)
  );

  assign out_data    = out_beat.dat;
  assign out_blk_end = out_beat.blk_end;
  assign out_final   = out_beat.fin;
  assign out_init    = out_beat.init;

endmodule

// File: rtl/sha_msg_padder_chk.sv
module sha_msg_padder_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_blk_end,
  input logic       out_final,
  input logic       out_init,
  input logic       accum_q
);

  // R1: nothing is offered in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R10: a stalled beat holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_blk_end) && $stable(out_final) && $stable(out_init)));

  // R6: final beat always closes a block
  p_final_blk_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_final) |-> out_blk_end);

  // R8: no first-block flag in accumulate mode
  p_init_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_init) |-> !accum_q);

  // R8: first-block flag ends with the first non-final block
  p_init_once_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_blk_end && !out_final) |=>
      !(out_valid && out_init));

endmodule

bind sha_msg_padder sha_msg_padder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_blk_end (out_blk_end),
  .out_final   (out_final),
  .out_init    (out_init),
  .accum_q     (accum_q)
);

// File: tb/sha_msg_padder_tb_top.sv
module sha_msg_padder_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wide, cfg_accum;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic       out_valid, out_ready;
  logic [7:0] out_data;
  logic       out_blk_end, out_final, out_init;

  always #10 clk = ~clk;

  sha_msg_padder dut_i (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_accum(cfg_accum),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_blk_end(out_blk_end), .out_final(out_final),
    .out_init(out_init)
  );

  typedef struct packed {
    logic [7:0] d;
    logic       be;
    logic       fi;
    logic       ini;
    logic [3:0] tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] msg[0:511];
  int         n_tests = 0;
  int         n_fail  = 0;
  int         msg_err = 0;
  bit         done    = 0;

  function automatic string tname(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Expected stream computed from the requirements
  function automatic void push_msg(int n, bit w, bit a);
    int blk  = w ? 128 : 64;
    int lf   = w ? 16 : 8;
    longint unsigned bits = longint'(n) * 8;
    int total;
    bit extra;
    exp_t e;
    if (a) begin
      for (int i = 0; i < n; i++) begin
        e.d = msg[i]; e.be = ((i % blk) == blk - 1) || (i == n - 1);
        e.fi = (i == n - 1); e.ini = 1'b0; e.tag = 4'd7;  // R7
        exp_q.push_back(e);
      end
    end else begin
      total = ((n + 1 + lf + blk - 1) / blk) * blk;
      extra = (n % blk) >= (blk - lf);                      // R5
      for (int i = 0; i < total; i++) begin
        if (i < n) begin e.d = msg[i]; e.tag = 4'd2; end
        else if (i == n) begin e.d = 8'h80; e.tag = 4'd2; end
        else if (i >= total - lf) begin
          int sel = lf - 1 - (i - (total - lf));
          e.d = (sel < 8) ? 8'(bits >> (8 * sel)) : 8'h00;
          e.tag = extra ? 4'd5 : 4'd4;                      // R4
        end else begin e.d = 8'h00; e.tag = extra ? 4'd5 : 4'd3; end
        e.be = (i % blk) == blk - 1; e.fi = (i == total - 1);
        e.ini = (i < blk);
        exp_q.push_back(e);
      end
    end
  endfunction

  // Consumer: random backpressure, byte-by-byte comparison
  initial begin
    exp_t e;
    bit   stalled = 0;
    logic [11:0] held = '0;
    out_ready = 1'b0;
    @(negedge clk);
    wait (!rst);
    forever begin
      @(negedge clk);
      if (stalled) begin
        n_tests++;  // R10: stalled beat must be unchanged
        if (!out_valid || {out_data, out_blk_end, out_final, out_init} != held) begin
          n_fail++;
          $display("FAIL R10 stall hold: actual %h expected %h", {out_valid, out_data, out_blk_end, out_final, out_init}, {1'b1, held});
        end
      end
      out_ready = ($urandom % 4) != 0;
      stalled = out_valid && !out_ready;
      held = {out_data, out_blk_end, out_final, out_init};
      if (out_valid && out_ready) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R3 extra byte: actual %h expected none", out_data);
        end else begin
          e = exp_q.pop_front();
          if (out_data != e.d) begin
            n_fail++; msg_err++;
            $display("FAIL %s data: actual %h expected %h", tname(int'(e.tag)), out_data, e.d);
          end else if (out_init != e.ini) begin
            n_fail++; msg_err++;
            $display("FAIL R8 init flag: actual %b expected %b", out_init, e.ini);
          end else if ({out_blk_end, out_final} != {e.be, e.fi}) begin
            n_fail++; msg_err++;
            $display("FAIL %s block flags: actual %b expected %b", (e.tag == 4'd7) ? "R7" : "R6", {out_blk_end, out_final}, {e.be, e.fi});
          end
          if (e.fi) begin
            n_tests++;  // R9: whole message framed with its first-byte mode
            if (msg_err != 0) begin
              n_fail++;
              $display("FAIL R9 message errors: actual %0d expected 0", msg_err);
            end
            msg_err = 0;
          end
        end
      end
    end
  end

  task automatic send_msg(int n, bit w, bit a, bit abc);
    for (int i = 0; i < n; i++) msg[i] = abc ? 8'(8'h61 + i) : 8'($urandom);
    push_msg(n, w, a);
    for (int i = 0; i < n; i++) begin
      while (($urandom % 5) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = msg[i]; in_last = (i == n - 1);
      cfg_wide  = (i == 0) ? w : 1'($urandom);  // R9: later changes ignored
      cfg_accum = (i == 0) ? a : 1'($urandom);
      #5;
      while (!in_ready) begin
        @(negedge clk); #5;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    cfg_wide = 1'b0; cfg_accum = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    n_tests++;  // R1
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset state: actual %b%b expected 01", out_valid, in_ready);
    end
    // Directed: short message, fit limit and extra-block cases (R4, R5)
    send_msg(3, 0, 0, 1);
    send_msg(55, 0, 0, 0);
    send_msg(56, 0, 0, 0);
    send_msg(63, 0, 0, 0);
    send_msg(64, 0, 0, 0);
    send_msg(1, 0, 0, 0);
    send_msg(3, 1, 0, 1);
    send_msg(111, 1, 0, 0);
    send_msg(112, 1, 0, 0);
    send_msg(127, 1, 0, 0);
    send_msg(128, 1, 0, 0);
    send_msg(300, 1, 0, 0);
    // Directed accumulate cases (R7)
    send_msg(64, 0, 1, 0);
    send_msg(128, 1, 1, 0);
    send_msg(100, 0, 1, 0);
    send_msg(1, 1, 1, 0);
    for (int m = 0; m < 30; m++)
      send_msg(1 + int'($urandom % 260), 1'($urandom), ($urandom % 4) == 0, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    n_tests++;  // R3: nothing after the last expected byte
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 idle after drain: actual %b expected 0", out_valid);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule